// File: doc/BRIEF.md
# Slave-Mode Sync Field Detector

This block sits behind an encoder's sync inputs when the encoder is timed by an external source. Each time the active-low vertical sync input falls, it decides whether the new field is odd or even. It holds that decision on a level output and marks the moment with a one-cycle pulse. Both sync inputs are active low, so a leading edge is a high-to-low transition. Each passes through a synchronizer before edge detection.

Three decision rules, picked by a 2-bit selector, work from the sync timing alone:
- **Window rule:** the vertical edge must fall within a quarter line of the horizontal edge or of mid-line. A horizontal position counter restarts at every horizontal leading edge to support this test.
- **Level rule:** the horizontal sync level is sampled when the vertical edge arrives.
- **Coincidence rule:** the two leading edges must land on the same clock.

When the build parameter `FIELD_SRC` is 1, the rules are replaced by a field pin with programmable polarity. The pin is sampled at each vertical leading edge.

Top module: `sync_parity_detect`

## Requirements
- R1: While `rst_n` is low, `odd_field` is 0 and `field_start` is 0.
- R2: Every input passes through `SYNC_STAGES` (default 2) flops. When `vs_n` is first sampled low after being sampled high, `field_start` is high for the one cycle that follows the second rising edge after that sample. It is low otherwise.
- R3: Position `pos` counts the clocks from the latest `hs_n` leading edge to the `vs_n` leading edge (0 when both land on the same clock). With `rule_sel` = 2'b00 and `pos < LINE_CLKS/4` or `pos > 3*LINE_CLKS/4`, `odd_field` becomes 1.
- R4: With `rule_sel` = 2'b00 and `LINE_CLKS/4 < pos < 3*LINE_CLKS/4`, `odd_field` becomes 0.
- R5: With `rule_sel` = 2'b00 and `pos` exactly `LINE_CLKS/4` or `3*LINE_CLKS/4`, `odd_field` keeps its value. `pos` stops at `LINE_CLKS-1` when no horizontal edge arrives, and after reset it starts at that limit.
- R6: With `rule_sel` = 2'b01, `odd_field` becomes 1 if the synchronized `hs_n` is low at the vertical edge, else 0.
- R7: With `rule_sel` = 2'b10 (intended reset-time setting), `odd_field` becomes 1 if an `hs_n` leading edge lands on the same clock as the vertical edge, else 0.
- R8: With `rule_sel` = 2'b11 (reserved), `odd_field` keeps its value, while `field_start` still pulses.
- R9: `odd_field` changes only in a cycle where `field_start` is high, and `field_start` is never high two cycles in a row.
- R10: With `FIELD_SRC` = 1, at each vertical edge `odd_field` becomes `fld_in` XNOR `fld_pol`. For the pin, `fld_in` is used as sampled on the same clock as the vertical edge. With `fld_pol` = 0, a high pin means even; with `fld_pol` = 1, a high pin means odd.
- R11: With `FIELD_SRC` = 1, `hs_n` and `rule_sel` have no effect on `odd_field` or `field_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_n | input | 1 | Horizontal sync, active low, asynchronous |
| vs_n | input | 1 | Vertical sync, active low, asynchronous |
| fld_in | input | 1 | External field pin, asynchronous |
| rule_sel | input | 2 | Decision rule: 00 window, 01 level, 10 coincidence, 11 reserved |
| fld_pol | input | 1 | Field pin polarity: 0 high means even, 1 high means odd |
| odd_field | output | 1 | 1 = current field odd, 0 = even |
| field_start | output | 1 | One-cycle pulse on each vertical leading edge |

## Verification
The hardest cases are the two exact window borders, where the flag must hold, and the saturated position after a long stretch without horizontal sync. Both need the vertical edge to land on a chosen clock relative to the horizontal edge. The bench drives whole lines in which the vertical edge is placed at every offset of interest, including both borders. Before each border case it presets the flag to a known opposite value, and it idles horizontal sync for several lines before one vertical edge. A long phase of random sync levels, rules and polarity then mixes edges, coincidences and reserved-mode holds. A behavioural model indexed by cycle tracks all of it.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

   typedef enum logic [1:0] {
      RULE_WINDOW   = 2'b00,
      RULE_LEVEL    = 2'b01,
      RULE_COINCIDE = 2'b10,
      RULE_RSVD     = 2'b11
   } rule_e;

   typedef struct packed {
      logic take;
      logic odd;
   } verdict_t;

   localparam int SYNC_HS  = 0;
   localparam int SYNC_VS  = 1;
   localparam int SYNC_FLD = 2;
   localparam int SYNC_W   = 3;

endpackage

// File: rtl/sfd_edge_sync.sv
module sfd_edge_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] fall
);

   logic [WIDTH-1:0] pipe [STAGES+1];

   initial begin
      assert (STAGES >= 2 && WIDTH >= 1)
         else $fatal(1, "sfd_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= din;
         for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign lvl  = pipe[STAGES-1];
   assign fall = pipe[STAGES] & ~pipe[STAGES-1];

   for (genvar b = 0; b < WIDTH; b++) begin : g_chk
      // R2: a detected leading edge lasts one cycle only
      a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
         fall[b] |=> !fall[b]);
   end

endmodule

// File: rtl/sfd_hpos.sv
module sfd_hpos #(
   parameter int LINE_CLKS = 1716
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_fall,
   output logic odd_win,
   output logic even_win
);

   localparam int PW   = $clog2(LINE_CLKS);
   localparam int QTR  = LINE_CLKS / 4;
   localparam int HI   = LINE_CLKS - QTR;
   localparam int LAST = LINE_CLKS - 1;

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] pos;

   initial begin
      assert (LINE_CLKS >= 8 && (LINE_CLKS % 4) == 0)
         else $fatal(1, "sfd_hpos: LINE_CLKS must be a multiple of 4, at least 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= PW'(LAST);
      else if (hs_fall)            cnt_q <= PW'(1);
      else if (cnt_q != PW'(LAST)) cnt_q <= cnt_q + 1'b1;
   end

   assign pos      = hs_fall ? '0 : cnt_q;
   assign odd_win  = (pos < PW'(QTR)) || (pos > PW'(HI));
   assign even_win = (pos > PW'(QTR)) && (pos < PW'(HI));

   // R5: position never passes the saturation limit
   a_r5_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= PW'(LAST));
   // R5: saturated counter stays put until a horizontal edge
   a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_fall && cnt_q == PW'(LAST)) |=> cnt_q == PW'(LAST));
   // R3: counter restarts after each horizontal edge
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      hs_fall |=> cnt_q == PW'(1));
   // R4: the two windows never overlap
   a_r4_win_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      !(odd_win && even_win));

endmodule

// File: rtl/sfd_rule.sv
module sfd_rule
   import sfd_pkg::*;
(
   input  rule_e    rule,
   input  logic     hs_lvl,
   input  logic     hs_fall,
   input  logic     odd_win,
   input  logic     even_win,
   output verdict_t verdict
);

   always_comb begin
      verdict = '0;
      case (rule)
         RULE_WINDOW: begin
            verdict.take = odd_win | even_win;
            verdict.odd  = odd_win;
         end
         RULE_LEVEL: begin
            verdict.take = 1'b1;
            verdict.odd  = ~hs_lvl;
         end
         RULE_COINCIDE: begin
            verdict.take = 1'b1;
            verdict.odd  = hs_fall;
         end
         default: verdict = '0;
      endcase
   end

   always_comb begin
      // R8: reserved code never yields a decision
      a_r8_rsvd_no_take: assert (rule != RULE_RSVD || !verdict.take);
   end

endmodule

// File: rtl/sync_parity_detect.sv
module sync_parity_detect
   import sfd_pkg::*;
#(
   parameter int LINE_CLKS   = 1716,
   parameter int SYNC_STAGES = 2,
   parameter int FIELD_SRC   = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_n,
   input  logic       vs_n,
   input  logic       fld_in,
   input  logic [1:0] rule_sel,
   input  logic       fld_pol,
   output logic       odd_field,
   output logic       field_start
);

   localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(3'b011);

   logic [SYNC_W-1:0] raw, lvl, fall;
   logic     hs_lvl, hs_fall, vs_fall, fld_lvl;
   verdict_t verdict;
   logic     odd_q, start_q;
   logic     unused_top;

   initial begin
      assert (FIELD_SRC == 0 || FIELD_SRC == 1)
         else $fatal(1, "sync_parity_detect: FIELD_SRC must be 0 or 1");
   end

   assign raw[SYNC_HS]  = hs_n;
   assign raw[SYNC_VS]  = vs_n;
   assign raw[SYNC_FLD] = fld_in;

   sfd_edge_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw),
      .lvl  (lvl),
      .fall (fall)
   );

   assign hs_lvl     = lvl[SYNC_HS];
   assign hs_fall    = fall[SYNC_HS];
   assign vs_fall    = fall[SYNC_VS];
   assign fld_lvl    = lvl[SYNC_FLD];
   assign unused_top = ^{lvl[SYNC_VS], fall[SYNC_FLD]};

   if (FIELD_SRC == 0) begin : g_sync_rules
      logic odd_win, even_win;
      logic unused_pin;

      sfd_hpos #(.LINE_CLKS(LINE_CLKS)) u_hpos (
         .clk     (clk),
         .rst_n   (rst_n),
         .hs_fall (hs_fall),
         .odd_win (odd_win),
         .even_win(even_win)
      );

      sfd_rule u_rule (
         .rule    (rule_e'(rule_sel)),
         .hs_lvl  (hs_lvl),
         .hs_fall (hs_fall),
         .odd_win (odd_win),
         .even_win(even_win),
         .verdict (verdict)
      );

      assign unused_pin = ^{fld_lvl, fld_pol};

      // R6: level rule follows horizontal sync level
      a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
         (vs_fall && rule_sel == 2'b01) |=> odd_field == !$past(hs_lvl));
      // R7: coincidence rule
      a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
         (vs_fall && rule_sel == 2'b10) |=> odd_field == $past(hs_fall));
      // R8: reserved rule holds the flag
      a_r8_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (vs_fall && rule_sel == 2'b11) |=> $stable(odd_field));
   end else begin : g_pin
      logic unused_rules;
      assign verdict.take = 1'b1;
      assign verdict.odd  = fld_lvl ~^ fld_pol;
      assign unused_rules = ^{hs_lvl, hs_fall, rule_sel};

      // R10: pin path with polarity
      a_r10_pin: assert property (@(posedge clk) disable iff (!rst_n)
         vs_fall |=> odd_field == ($past(fld_lvl) ~^ $past(fld_pol)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= vs_fall;
         if (vs_fall && verdict.take) odd_q <= verdict.odd;
      end
   end

   assign odd_field   = odd_q;
   assign field_start = start_q;

   // R9: pulse is one cycle wide
   a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> !field_start);
   // R9: flag moves only together with the pulse
   a_r9_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |-> $stable(odd_field));

endmodule

// File: tb/sim_sync_parity_detect.sv
module sim_sync_parity_detect;

   localparam int L   = 32;
   localparam int Q   = L / 4;
   localparam int HSW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hs_n = 1'b1, vs_n = 1'b1, fld_in = 1'b0, fld_pol = 1'b0;
   logic [1:0] rule_sel = 2'b10;
   logic odd0, st0, odd1, st1;

   int n_cmp = 0, n_bad = 0;
   string req0 = "R1", req1 = "R1";

   always #5 clk = ~clk;

   sync_parity_detect #(.LINE_CLKS(L), .FIELD_SRC(0)) u0 (
      .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .vs_n(vs_n), .fld_in(fld_in),
      .rule_sel(rule_sel), .fld_pol(fld_pol), .odd_field(odd0), .field_start(st0));

   sync_parity_detect #(.LINE_CLKS(L), .FIELD_SRC(1)) u1 (
      .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .vs_n(vs_n), .fld_in(fld_in),
      .rule_sel(rule_sel), .fld_pol(fld_pol), .odd_field(odd1), .field_start(st1));

   // behavioural reference: history of sampled inputs indexed by age
   bit hh[4], vh[4], fh[4];
   int cyc, last_hs;
   bit m_odd0, m_st0, m_odd1, m_st1;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin hh[i] = 1; vh[i] = 1; fh[i] = 0; end
         cyc = 0; last_hs = -1000000;
         m_odd0 = 0; m_st0 = 0; m_odd1 = 0; m_st1 = 0;
      end else begin
         int pos;
         bit hf, vf;
         cyc++;
         for (int i = 3; i > 0; i--) begin hh[i] = hh[i-1]; vh[i] = vh[i-1]; fh[i] = fh[i-1]; end
         hh[0] = hs_n; vh[0] = vs_n; fh[0] = fld_in;
         hf = hh[3] && !hh[2];
         vf = vh[3] && !vh[2];
         if (hf) last_hs = cyc;
         pos = hf ? 0 : (((cyc - last_hs) > L - 1) ? L - 1 : cyc - last_hs);
         m_st0 = vf; m_st1 = vf;
         if (vf) begin
            case (rule_sel)
               2'b00: if (pos < Q || pos > L - Q) m_odd0 = 1;
                      else if (pos > Q && pos < L - Q) m_odd0 = 0;
               2'b01: m_odd0 = !hh[2];
               2'b10: m_odd0 = hf;
               default: ;
            endcase
            m_odd1 = (fh[2] == fld_pol);
         end
      end
   end

   task automatic check(input string req, input string what, input bit act, input bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(req0, "u0 odd_field", odd0, m_odd0);
         check(req0, "u0 field_start", st0, m_st0);
         check(req1, "u1 odd_field", odd1, m_odd1);
         check(req1, "u1 field_start", st1, m_st1);
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // one line of L clocks; vertical edge at offset vs_at (negative: none)
   task automatic run_line(input int vs_at);
      for (int c = 0; c < L; c++) begin
         @(negedge clk);
         hs_n = (c < HSW) ? 1'b0 : 1'b1;
         vs_n = (vs_at >= 0 && c >= vs_at && c < vs_at + 4) ? 1'b0 : 1'b1;
         if (c == 0) fld_in = 1'($urandom % 2);
      end
   endtask

   task automatic idle(input int clks);
      for (int c = 0; c < clks; c++) begin
         @(negedge clk); hs_n = 1'b1; vs_n = 1'b1;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "u0 odd_field in reset", odd0, 1'b0);
      check("R1", "u0 field_start in reset", st0, 1'b0);
      check("R1", "u1 odd_field in reset", odd1, 1'b0);
      check("R1", "u1 field_start in reset", st1, 1'b0);
      rst_n = 1'b1;
      idle(8);

      // R7 coincidence rule, default setting; R10 pin path alongside
      req0 = "R7"; req1 = "R10";
      for (int k = 0; k < 6; k++) begin
         run_line(-1); run_line(k == 0 ? 0 : k * 5);
         fld_pol = ~fld_pol;
      end

      // window rule, every offset incl. borders (R3 R4 R5)
      rule_sel = 2'b00;
      for (int v = 0; v < L; v++) begin
         req0 = (v == Q || v == L - Q) ? "R5" : ((v < Q || v > L - Q) ? "R3" : "R4");
         run_line(-1);
         run_line((v == Q || v == L - Q) ? ((v == Q) ? 16 : 0) : -1);
         run_line(v);
         if (v == Q || v == L - Q) begin
            run_line(-1);
            run_line((v == Q) ? 0 : 16);
            run_line(v);
         end
      end

      // R5 saturation: no horizontal edge for several lines
      req0 = "R5";
      run_line(16);
      idle(3 * L);
      @(negedge clk); vs_n = 1'b0;
      idle(L);

      // R6 level rule
      rule_sel = 2'b01; req0 = "R6";
      for (int v = 0; v < 12; v++) begin run_line(-1); run_line(v); end

      // R8 reserved rule: both prior states
      req0 = "R8";
      rule_sel = 2'b10; run_line(-1); run_line(0);
      rule_sel = 2'b11; run_line(-1); run_line(16); run_line(-1); run_line(0);
      rule_sel = 2'b10; run_line(-1); run_line(16);
      rule_sel = 2'b11; run_line(-1); run_line(0);

      // R9 R11 random sync activity with random rules and polarity
      req0 = "R9"; req1 = "R11";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         hs_n   = ($urandom % 5) != 0;
         vs_n   = ($urandom % 7) != 0;
         fld_in = 1'($urandom % 2);
         if (i % 40 == 0) begin
            rule_sel = 2'($urandom % 4);
            fld_pol  = 1'($urandom % 2);
         end
      end
      idle(8);
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
   end

endmodule